// File: doc/BRIEF.md
# Parking Meter Countdown Controller

This block holds the number of parking seconds still paid for and lowers it by one every second. Four credit strobes each buy a fixed amount of time. An internal divider turns the system clock into a one-second tick and a half-second tick, so the block needs only the clock and the strobes. The strobes are expected to be clean and one clock wide. Debouncing and pulse shaping happen upstream.

The binary balance goes to a display path outside this block. Two indicator outputs show how much time is left. Green blinks slowly while there is plenty of time. Red blinks slowly when the time is nearly gone. Red blinks fast once the meter has expired. All blink waveforms use the same half-second phase counter, which starts from reset, so their edges can be predicted to the cycle.

Top module: `parking_meter_ctrl`

## Requirements
- R1: Strobe bits `credit_stb[0]`, `[1]`, `[2]` and `[3]` add 50, 150, 250 and 500 seconds to the balance at the next clock edge.
- R2: A one-second tick fires on the edge where the divider reaches `CLK_PER_SEC`-1. The first tick is the `CLK_PER_SEC`-th edge after reset is released, and then one follows every `CLK_PER_SEC` edges. Each tick lowers the balance by one. The balance never goes below zero.
- R3: The balance saturates at 9999 and never reads higher.
- R4: When several strobes are high in one cycle, their values are added together. When a credit arrives on a tick edge, the new balance is the old balance plus the credit minus one, then saturated. The minus one is skipped only if that sum is zero.
- R5: While the balance is 10 or more, red is low. Green is high for the first second of each two-second period and low for the second.
- R6: While the balance is 1 to 9, green is low. Red is high for the first second of each two-second period and low for the second.
- R7: At a balance of zero, green is low. Red is high for the first half-second of each second and low for the second half.
- R8: Synchronous active-high reset clears the balance, both indicators, the divider and the blink phase. The indicator outputs are registered, so they reflect the balance and phase from one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| credit_stb | input | 4 | One-cycle credit strobes; bit 0 adds 50 s, bit 1 adds 150 s, bit 2 adds 250 s, bit 3 adds 500 s |
| balance | output | BAL_W (14) | Remaining seconds in binary, 0 to 9999 |
| led_green | output | 1 | Green indicator level |
| led_red | output | 1 | Red indicator level |

## Verification
A strobe shows in `balance` at the first edge after it is sampled. A tick changes `balance` at the edge numbered `CLK_PER_SEC`-1 modulo `CLK_PER_SEC`, counted from reset release. The indicators lag by one more edge, because they are registered from the previous balance and phase. The bench counts edges since reset and derives the tick and phase by division of that count. It updates its expected state on each rising edge and compares on the falling edge. Stimulus aligned to ticks is timed with the same edge count, so credit-on-tick and zero-floor cases fall in known cycles.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    ZONE_EMPTY = 2'd0,
    ZONE_LOW   = 2'd1,
    ZONE_OK    = 2'd2
  } zone_e;

  // new balance: add credit, take one second if a tick and something to take, clamp
  function automatic int unsigned next_balance(input int unsigned bal,
                                               input int unsigned credit,
                                               input logic        dec,
                                               input int unsigned cap);
    int unsigned s;
    s = bal + credit;
    if (dec && s != 0) s = s - 1;
    if (s > cap) s = cap;
    return s;
  endfunction

  function automatic zone_e zone_of(input int unsigned bal,
                                    input int unsigned green_min);
    if (bal == 0)         return ZONE_EMPTY;
    if (bal < green_min)  return ZONE_LOW;
    return ZONE_OK;
  endfunction

  // phase counts half seconds modulo 4; result is {green, red}
  function automatic logic [1:0] led_pair(input zone_e z, input logic [1:0] phase);
    logic slow_on;
    logic fast_on;
    slow_on = ~phase[1];
    fast_on = ~phase[0];
    case (z)
      ZONE_OK:    return {slow_on, 1'b0};
      ZONE_LOW:   return {1'b0, slow_on};
      default:    return {1'b0, fast_on};
    endcase
  endfunction

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int unsigned CLK_PER_SEC = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic sec_tick,
  output logic half_tick
);
  localparam int unsigned HALF  = CLK_PER_SEC / 2;
  localparam int unsigned CNT_W = (CLK_PER_SEC > 2) ? $clog2(CLK_PER_SEC) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign sec_tick  = (cnt_q == CNT_W'(CLK_PER_SEC - 1));
  assign half_tick = sec_tick || (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (sec_tick) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_credit_sum.sv
module pm_credit_sum #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned CVAL_W  = 16,
  parameter logic [NUM_SRC*CVAL_W-1:0] CREDITS = {16'd500, 16'd250, 16'd150, 16'd50},
  parameter int unsigned SUM_W   = 16
) (
  input  logic [NUM_SRC-1:0] strobe,
  output logic [SUM_W-1:0]   credit_sum
);
  logic [SUM_W-1:0] term [NUM_SRC];

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_term
    assign term[gi] = strobe[gi] ? SUM_W'(CREDITS[gi*CVAL_W +: CVAL_W]) : '0;
  end

  always_comb begin
    credit_sum = '0;
    for (int i = 0; i < NUM_SRC; i++) credit_sum = credit_sum + term[i];
  end
endmodule

// File: rtl/pm_balance.sv
module pm_balance #(
  parameter int unsigned BAL_W   = 14,
  parameter int unsigned SUM_W   = 16,
  parameter int unsigned MAX_BAL = 9999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] credit_sum,
  input  logic             sec_tick,
  output logic [BAL_W-1:0] bal_q
);
  logic [BAL_W-1:0] bal_d;

  always_comb begin
    bal_d = BAL_W'(pm_pkg::next_balance(32'(bal_q), 32'(credit_sum), sec_tick, MAX_BAL));
  end

  always_ff @(posedge clk) begin
    if (rst) bal_q <= '0;
    else     bal_q <= bal_d;
  end
endmodule

// File: rtl/pm_blink.sv
module pm_blink #(
  parameter int unsigned BAL_W     = 14,
  parameter int unsigned GREEN_MIN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_tick,
  input  logic [BAL_W-1:0] bal,
  output logic             green_q,
  output logic             red_q
);
  logic [1:0]    phase_q;
  pm_pkg::zone_e zone;
  logic [1:0]    pair;

  assign zone = pm_pkg::zone_of(32'(bal), GREEN_MIN);
  assign pair = pm_pkg::led_pair(zone, phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      green_q <= 1'b0;
      red_q   <= 1'b0;
    end else begin
      if (half_tick) phase_q <= phase_q + 2'd1;
      green_q <= pair[1];
      red_q   <= pair[0];
    end
  end
endmodule

// File: rtl/parking_meter_ctrl.sv
module parking_meter_ctrl #(
  parameter int unsigned CLK_PER_SEC = 125_000_000,
  parameter int unsigned MAX_BAL     = 9999,
  parameter int unsigned GREEN_MIN   = 10,
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned CVAL_W      = 16,
  parameter logic [NUM_SRC*CVAL_W-1:0] CREDITS = {16'd500, 16'd250, 16'd150, 16'd50},
  parameter int unsigned BAL_W       = $clog2(MAX_BAL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] credit_stb,
  output logic [BAL_W-1:0]   balance,
  output logic               led_green,
  output logic               led_red
);
  localparam int unsigned SUM_W = CVAL_W + $clog2(NUM_SRC + 1) + 1;

  logic             sec_tick;
  logic             half_tick;
  logic [SUM_W-1:0] credit_sum;

  pm_tick_gen #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .half_tick(half_tick)
  );

  pm_credit_sum #(.NUM_SRC(NUM_SRC), .CVAL_W(CVAL_W), .CREDITS(CREDITS), .SUM_W(SUM_W)) u_sum (
    .strobe(credit_stb), .credit_sum(credit_sum)
  );

  pm_balance #(.BAL_W(BAL_W), .SUM_W(SUM_W), .MAX_BAL(MAX_BAL)) u_bal (
    .clk(clk), .rst(rst), .credit_sum(credit_sum), .sec_tick(sec_tick), .bal_q(balance)
  );

  pm_blink #(.BAL_W(BAL_W), .GREEN_MIN(GREEN_MIN)) u_blink (
    .clk(clk), .rst(rst), .half_tick(half_tick), .bal(balance),
    .green_q(led_green), .red_q(led_red)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int unsigned BAL_W     = 14,
  parameter int unsigned SUM_W     = 16,
  parameter int unsigned MAX_BAL   = 9999,
  parameter int unsigned GREEN_MIN = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [BAL_W-1:0] balance,
  input logic             led_green,
  input logic             led_red,
  input logic             sec_tick,
  input logic [SUM_W-1:0] credit_sum
);
  assert_cap_R3: assert property (@(posedge clk) disable iff (rst)
    32'(balance) <= MAX_BAL);

  assert_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (balance == '0 && credit_sum == '0) |=> balance == '0);

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && credit_sum == '0 && balance != '0) |=> 32'(balance) == 32'($past(balance)) - 1);

  assert_credit_R1: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && credit_sum != '0 && 32'(balance) + 32'(credit_sum) <= MAX_BAL)
      |=> 32'(balance) == 32'($past(balance)) + 32'($past(credit_sum)));

  assert_one_colour_R5: assert property (@(posedge clk) disable iff (rst)
    !(led_green && led_red));

  assert_green_zone_R5: assert property (@(posedge clk) disable iff (rst)
    led_green |-> 32'($past(balance)) >= GREEN_MIN);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (balance == '0 && !led_green && !led_red));
endmodule

bind parking_meter_ctrl pm_checker #(
  .BAL_W(BAL_W), .SUM_W(SUM_W), .MAX_BAL(MAX_BAL), .GREEN_MIN(GREEN_MIN)
) u_pm_checker (
  .clk(clk), .rst(rst), .balance(balance), .led_green(led_green), .led_red(led_red),
  .sec_tick(sec_tick), .credit_sum(credit_sum)
);

// File: tb/parking_meter_ctrl_test.sv
module parking_meter_ctrl_test;
  localparam int CPS  = 8;
  localparam int HALF = CPS / 2;
  localparam int CAP  = 9999;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  stb = 4'b0;
  logic [13:0] balance;
  logic        led_green, led_red;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  parking_meter_ctrl #(.CLK_PER_SEC(CPS)) uut (
    .clk(clk), .rst(rst), .credit_stb(stb),
    .balance(balance), .led_green(led_green), .led_red(led_red)
  );

  // bench model: edge count since reset release gives tick and phase by division
  int    m_k   = 0;
  int    m_bal = 0;
  bit    m_g   = 0;
  bit    m_r   = 0;
  string m_btag = "R8";
  string m_ltag = "R8";

  function automatic int value_of(input logic [3:0] v);
    return (v[0] ? 50 : 0) + (v[1] ? 150 : 0) + (v[2] ? 250 : 0) + (v[3] ? 500 : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_k <= 0; m_bal <= 0; m_g <= 0; m_r <= 0; m_btag <= "R8"; m_ltag <= "R8";
    end else begin
      int  add, nb, ph;
      bit  tick;
      add  = value_of(stb);
      tick = ((m_k + 1) % CPS) == 0;
      nb   = m_bal + add;
      if (tick && nb > 0) nb = nb - 1;
      if (nb > CAP) nb = CAP;
      ph = (m_k / HALF) % 4;
      m_g <= (m_bal >= 10) && (ph < 2);
      m_r <= ((m_bal > 0 && m_bal < 10) && (ph < 2)) || (m_bal == 0 && (ph % 2) == 0);
      m_ltag <= (m_bal >= 10) ? "R5" : (m_bal > 0 ? "R6" : "R7");
      m_btag <= (nb == CAP) ? "R3" : (add > 0 && tick) ? "R4" : (add > 0) ? "R1" : "R2";
      m_bal <= nb;
      m_k   <= m_k + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(balance) != m_bal) begin
        fails++;
        $display("FAIL %s balance actual=%0d expected=%0d", m_btag, balance, m_bal);
      end
      checks++;
      if (led_green !== m_g || led_red !== m_r) begin
        fails++;
        $display("FAIL %s leds(g,r) actual=%b%b expected=%b%b", m_ltag, led_green, led_red, m_g, m_r);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    // R8: outputs cleared while reset is held
    checks++;
    if (balance !== 14'd0 || led_green || led_red) begin
      fails++;
      $display("FAIL R8 reset state actual=%0d%b%b expected=000", balance, led_green, led_red);
    end
    rst = 1'b0;
  endtask

  task automatic press(input logic [3:0] v);
    @(negedge clk); stb = v;
    @(negedge clk); stb = 4'b0;
  endtask

  task automatic press_on_tick(input logic [3:0] v);
    do @(negedge clk); while (((m_k + 1) % CPS) != 0);
    stb = v;
    @(negedge clk); stb = 4'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    idle(3 * CPS);                 // R7 fast red at zero, R2 floor
    press(4'b0001);                // R1 +50
    idle(5 * CPS);                 // R5 green blink
    press(4'b0010); idle(CPS + 3);
    press(4'b0100); idle(CPS + 1);
    press(4'b1000); idle(2 * CPS);
    // R4 exhaustive strobe combinations, off tick and on tick
    for (int c = 1; c < 16; c++) begin
      do_reset();
      press(4'(c)); idle(3);
      press_on_tick(4'(c)); idle(2);
    end
    // R4 credit on tick from empty meter: 0 + 50 - 1
    do_reset();
    idle(2 * CPS);
    press_on_tick(4'b0001); idle(2 * CPS);
    // R3 saturation, then credit on tick at cap
    for (int i = 0; i < 11; i++) press(4'b1111);
    idle(3);
    press_on_tick(4'b1000); idle(CPS);
    // R8 reset mid-run
    do_reset();
    idle(4);
    // R2 countdown through 10, R6 low zone, R7 empty
    press(4'b0001);
    idle(56 * CPS);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule